// File: doc/BRIEF.md
# Outstanding Miss Countdown Buffer

This block keeps track of cache misses that are waiting for the next memory level. Each accepted miss becomes an entry holding its set index, its tag, the requesting thread identifier and a count of the cycles still to wait. Entries are kept sorted by that count, smallest first. All counts fall by one on every clock. When an entry reaches zero it leaves the buffer and goes back to the tag directory as a fill.

Entries that reach zero at the same time leave the buffer together at one edge. They enter a small output queue, and the queue presents them to the directory one per cycle. A combinational search port lets the lookup logic ask whether a request matches an outstanding miss. When it does, the port returns the entry's slot and its remaining count, which the caller can use as the latency of a partial hit.

Top module: `miss_countdown_buf`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `push_full` is 0, `fill_valid` is 0, and a search misses with `srch_slot` equal to 0.
- R2: A push accepted at a rising edge appears in the next cycle. A search then finds it with `srch_dly` equal to the pushed delay, and `occupancy` has risen by one.
- R3: The remaining delay of each stored entry falls by exactly one at every rising edge and never goes below zero.
- R4: Take an entry accepted at edge t with delay D, where no earlier fill is still waiting. Its set, tag and thread identifier appear on the fill outputs, with `fill_valid` high, in the cycle that follows edge t+D+1.
- R5: Slots are numbered from the head, with slot 0 holding the smallest remaining delay. Delays rise with the slot index. Entries with equal delay stay in the order they were pushed, and fills are issued in slot order.
- R6: All entries that reach zero together leave the buffer at the same edge. Their fills follow on consecutive cycles, one per cycle.
- R7: `push_full` is high exactly when `occupancy` equals DEPTH (5 by default). A push made while the buffer is full is refused: `occupancy` does not change and no fill is ever produced for it.
- R8: A search hits only when thread identifier, tag and set all match a stored entry. On a hit it returns the lowest matching slot and that slot's remaining delay. On a miss `srch_hit` is 0, `srch_slot` equals `occupancy` and `srch_dly` is 0.
- R9: A search that differs from a stored entry in only one field (thread, tag or set) misses.
- R10: `occupancy` falls at the edge where an entry leaves the buffer for the output queue, which is edge t+D+1 for an entry accepted at edge t with delay D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Request to record a new miss |
| push_set | input | SET_W | Set index of the miss |
| push_tag | input | TAG_W | Tag of the miss |
| push_tid | input | TID_W | Thread identifier of the miss |
| push_dly | input | DLY_W | Cycles to wait before the fill |
| push_full | output | 1 | Buffer full; a push is refused |
| srch_set | input | SET_W | Set index to look up |
| srch_tag | input | TAG_W | Tag to look up |
| srch_tid | input | TID_W | Thread identifier to look up |
| srch_hit | output | 1 | A stored entry matches |
| srch_slot | output | SLOT_W | First matching slot, or occupancy on a miss |
| srch_dly | output | DLY_W | Remaining delay of the matching entry |
| fill_valid | output | 1 | A fill is presented this cycle |
| fill_set | output | SET_W | Set index of the fill |
| fill_tag | output | TAG_W | Tag of the fill |
| fill_tid | output | TID_W | Thread identifier of the fill |
| occupancy | output | SLOT_W | Number of stored entries |

## Verification
The search outputs are combinational on the stored state. They are sampled one time unit after the search inputs are driven at the falling edge, in the same cycle. A push is visible to search and to `occupancy` in the cycle after its sampling edge. Its fill is due D+2 cycles after the falling edge at which it was driven, or one cycle after the previous fill if that is later. The scoreboard computes this due cycle for each push and checks each fill against it, and it reports a fill that arrives early, late or unexpectedly. Expected occupancy is recomputed at every falling edge from the push and removal edges the bench has recorded.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   parameter int MCB_DEF_DEPTH = 5;
   parameter int MCB_DEF_SET_W = 6;
   parameter int MCB_DEF_TAG_W = 20;
   parameter int MCB_DEF_TID_W = 4;
   parameter int MCB_DEF_DLY_W = 8;
endpackage

// File: rtl/mcb_sort_store.sv
module mcb_sort_store #(
   parameter int DEPTH = 5,
   parameter int KEY_W = 30,
   parameter int DLY_W = 8,
   parameter int CNT_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push_valid,
   input  logic [KEY_W-1:0]       push_key,
   input  logic [DLY_W-1:0]       push_dly,
   input  logic [CNT_W-1:0]       drain_room,
   output logic                   full,
   output logic [CNT_W-1:0]       occ,
   output logic [CNT_W-1:0]       drain_cnt,
   output logic [DEPTH*KEY_W-1:0] key_flat,
   output logic [DEPTH*DLY_W-1:0] dly_flat
);
   logic [KEY_W-1:0] key_q [DEPTH];
   logic [KEY_W-1:0] key_n [DEPTH];
   logic [KEY_W-1:0] sh_key [DEPTH];
   logic [DLY_W-1:0] dly_q [DEPTH];
   logic [DLY_W-1:0] dly_n [DEPTH];
   logic [DLY_W-1:0] sh_dly [DEPTH];
   logic [CNT_W-1:0] occ_q;
   logic [CNT_W-1:0] occ_n;
   logic             accept;
   int               n_zero;
   int               n_drain;
   int               n_left;
   int               ins_pos;

   // expired entries sit at the head because the array is sorted
   always_comb begin
      n_zero = 0;
      for (int i = 0; i < DEPTH; i++) begin
         if (i < int'(occ_q) && dly_q[i] == '0) n_zero = n_zero + 1;
      end
      n_drain = (n_zero < int'(drain_room)) ? n_zero : int'(drain_room);
      n_left  = int'(occ_q) - n_drain;
   end

   // remove drained head, then age the survivors
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         if (j + n_drain < DEPTH) begin
            sh_key[j] = key_q[j + n_drain];
            sh_dly[j] = (dly_q[j + n_drain] == '0) ? '0 : dly_q[j + n_drain] - 1'b1;
         end else begin
            sh_key[j] = '0;
            sh_dly[j] = '0;
         end
      end
   end

   // insertion point: after every survivor whose delay is not larger
   always_comb begin
      ins_pos = 0;
      for (int j = 0; j < DEPTH; j++) begin
         if (j < n_left && sh_dly[j] <= push_dly) ins_pos = ins_pos + 1;
      end
      accept = push_valid && (int'(occ_q) < DEPTH);
      for (int j = 0; j < DEPTH; j++) begin
         if (!accept || j < ins_pos) begin
            key_n[j] = sh_key[j];
            dly_n[j] = sh_dly[j];
         end else if (j == ins_pos) begin
            key_n[j] = push_key;
            dly_n[j] = push_dly;
         end else begin
            key_n[j] = sh_key[(j == 0) ? 0 : j - 1];
            dly_n[j] = sh_dly[(j == 0) ? 0 : j - 1];
         end
      end
      occ_n = CNT_W'(n_left + (accept ? 1 : 0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            key_q[k] <= '0;
            dly_q[k] <= '0;
         end
      end else begin
         occ_q <= occ_n;
         for (int k = 0; k < DEPTH; k++) begin
            key_q[k] <= key_n[k];
            dly_q[k] <= dly_n[k];
         end
      end
   end

   assign full      = (occ_q == CNT_W'(DEPTH));
   assign occ       = occ_q;
   assign drain_cnt = CNT_W'(n_drain);

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign key_flat[g*KEY_W +: KEY_W] = key_q[g];
      assign dly_flat[g*DLY_W +: DLY_W] = dly_q[g];
   end
endmodule

// File: rtl/mcb_assoc_search.sv
module mcb_assoc_search #(
   parameter int DEPTH = 5,
   parameter int KEY_W = 30,
   parameter int DLY_W = 8,
   parameter int CNT_W = 3
) (
   input  logic [DEPTH*KEY_W-1:0] key_flat,
   input  logic [DEPTH*DLY_W-1:0] dly_flat,
   input  logic [CNT_W-1:0]       occ,
   input  logic [KEY_W-1:0]       look_key,
   output logic                   hit,
   output logic [CNT_W-1:0]       slot,
   output logic [DLY_W-1:0]       dly
);
   logic [DEPTH-1:0] match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = (CNT_W'(g) < occ) && (key_flat[g*KEY_W +: KEY_W] == look_key);
   end

   // scan from the tail so the lowest matching slot wins
   always_comb begin
      hit  = 1'b0;
      slot = occ;
      dly  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit  = 1'b1;
            slot = CNT_W'(i);
            dly  = dly_flat[i*DLY_W +: DLY_W];
         end
      end
   end
endmodule

// File: rtl/mcb_fill_queue.sv
module mcb_fill_queue #(
   parameter int QDEPTH = 5,
   parameter int DEPTH  = 5,
   parameter int KEY_W  = 30,
   parameter int CNT_W  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       wr_cnt,
   input  logic [DEPTH*KEY_W-1:0] wr_flat,
   output logic [CNT_W-1:0]       room,
   output logic                   head_valid,
   output logic [KEY_W-1:0]       head_key
);
   localparam int QCNT_W = $clog2(QDEPTH + 1);

   logic [KEY_W-1:0]  q_q [QDEPTH];
   logic [KEY_W-1:0]  q_n [QDEPTH];
   logic [QCNT_W-1:0] cnt_q;
   logic [QCNT_W-1:0] cnt_n;
   int                pop;
   int                base;
   int                free_sl;

   // the directory takes one fill every cycle, so the head always pops
   always_comb begin
      pop     = (cnt_q != '0) ? 1 : 0;
      base    = int'(cnt_q) - pop;
      free_sl = QDEPTH - base;
      room    = (free_sl > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(free_sl);
      for (int i = 0; i < QDEPTH; i++) begin
         if (i < base) begin
            q_n[i] = q_q[(i + pop < QDEPTH) ? i + pop : i];
         end else if (i - base < int'(wr_cnt)) begin
            q_n[i] = wr_flat[(i - base)*KEY_W +: KEY_W];
         end else begin
            q_n[i] = q_q[i];
         end
      end
      cnt_n = QCNT_W'(base + int'(wr_cnt));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < QDEPTH; k++) q_q[k] <= '0;
      end else begin
         cnt_q <= cnt_n;
         for (int k = 0; k < QDEPTH; k++) q_q[k] <= q_n[k];
      end
   end

   assign head_valid = (cnt_q != '0);
   assign head_key   = q_q[0];
endmodule

// File: rtl/miss_countdown_buf.sv
module miss_countdown_buf
   import mcb_pkg::*;
#(
   parameter int DEPTH       = MCB_DEF_DEPTH,
   parameter int SET_W       = MCB_DEF_SET_W,
   parameter int TAG_W       = MCB_DEF_TAG_W,
   parameter int TID_W       = MCB_DEF_TID_W,
   parameter int DLY_W       = MCB_DEF_DLY_W,
   parameter int FILLQ_DEPTH = DEPTH,
   localparam int SLOT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [SET_W-1:0]  push_set,
   input  logic [TAG_W-1:0]  push_tag,
   input  logic [TID_W-1:0]  push_tid,
   input  logic [DLY_W-1:0]  push_dly,
   output logic              push_full,
   input  logic [SET_W-1:0]  srch_set,
   input  logic [TAG_W-1:0]  srch_tag,
   input  logic [TID_W-1:0]  srch_tid,
   output logic              srch_hit,
   output logic [SLOT_W-1:0] srch_slot,
   output logic [DLY_W-1:0]  srch_dly,
   output logic              fill_valid,
   output logic [SET_W-1:0]  fill_set,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [TID_W-1:0]  fill_tid,
   output logic [SLOT_W-1:0] occupancy
);
   localparam int KEY_W = SET_W + TAG_W + TID_W;

   if (DEPTH < 1) begin : g_bad_depth
      $error("miss_countdown_buf: DEPTH must be at least 1");
   end
   if (FILLQ_DEPTH < 1) begin : g_bad_fillq
      $error("miss_countdown_buf: FILLQ_DEPTH must be at least 1");
   end
   if (DLY_W < 1 || SET_W < 1 || TAG_W < 1 || TID_W < 1) begin : g_bad_width
      $error("miss_countdown_buf: field widths must be at least 1");
   end

   logic [KEY_W-1:0]       push_key;
   logic [KEY_W-1:0]       srch_key;
   logic [KEY_W-1:0]       head_key;
   logic [DEPTH*KEY_W-1:0] key_flat;
   logic [DEPTH*DLY_W-1:0] dly_flat;
   logic [SLOT_W-1:0]      drain_cnt;
   logic [SLOT_W-1:0]      drain_room;

   assign push_key = {push_tid, push_tag, push_set};
   assign srch_key = {srch_tid, srch_tag, srch_set};

   mcb_sort_store #(
      .DEPTH(DEPTH), .KEY_W(KEY_W), .DLY_W(DLY_W), .CNT_W(SLOT_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid),
      .push_key   (push_key),
      .push_dly   (push_dly),
      .drain_room (drain_room),
      .full       (push_full),
      .occ        (occupancy),
      .drain_cnt  (drain_cnt),
      .key_flat   (key_flat),
      .dly_flat   (dly_flat)
   );

   mcb_assoc_search #(
      .DEPTH(DEPTH), .KEY_W(KEY_W), .DLY_W(DLY_W), .CNT_W(SLOT_W)
   ) u_search (
      .key_flat (key_flat),
      .dly_flat (dly_flat),
      .occ      (occupancy),
      .look_key (srch_key),
      .hit      (srch_hit),
      .slot     (srch_slot),
      .dly      (srch_dly)
   );

   mcb_fill_queue #(
      .QDEPTH(FILLQ_DEPTH), .DEPTH(DEPTH), .KEY_W(KEY_W), .CNT_W(SLOT_W)
   ) u_fillq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cnt     (drain_cnt),
      .wr_flat    (key_flat),
      .room       (drain_room),
      .head_valid (fill_valid),
      .head_key   (head_key)
   );

   assign {fill_tid, fill_tag, fill_set} = head_key;
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker #(
   parameter int DEPTH  = 5,
   parameter int DLY_W  = 8,
   parameter int SLOT_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   push_valid,
   input logic                   push_full,
   input logic [SLOT_W-1:0]      occupancy,
   input logic                   srch_hit,
   input logic [SLOT_W-1:0]      srch_slot,
   input logic [DEPTH*DLY_W-1:0] dly_flat
);
   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= SLOT_W'(DEPTH)); // R7

   AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && push_full) |=> (occupancy <= $past(occupancy))); // R7

   AST_GROW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1)); // R2

   AST_HIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      srch_hit |-> (srch_slot < occupancy)); // R8

   AST_MISS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_hit |-> (srch_slot == occupancy)); // R8

   for (genvar g = 0; g < DEPTH - 1; g++) begin : g_ord
      AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
         (SLOT_W'(g + 1) < occupancy) |->
         (dly_flat[g*DLY_W +: DLY_W] <= dly_flat[(g+1)*DLY_W +: DLY_W])); // R5
   end
endmodule

bind miss_countdown_buf mcb_checker #(
   .DEPTH(DEPTH), .DLY_W(DLY_W), .SLOT_W(SLOT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .push_full  (push_full),
   .occupancy  (occupancy),
   .srch_hit   (srch_hit),
   .srch_slot  (srch_slot),
   .dly_flat   (dly_flat)
);

// File: tb/miss_countdown_buf_test.sv
module miss_countdown_buf_test;
   localparam int DEPTH  = 5;
   localparam int SET_W  = 6;
   localparam int TAG_W  = 20;
   localparam int TID_W  = 4;
   localparam int DLY_W  = 8;
   localparam int SLOT_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              push_valid;
   logic [SET_W-1:0]  push_set;
   logic [TAG_W-1:0]  push_tag;
   logic [TID_W-1:0]  push_tid;
   logic [DLY_W-1:0]  push_dly;
   logic              push_full;
   logic [SET_W-1:0]  srch_set;
   logic [TAG_W-1:0]  srch_tag;
   logic [TID_W-1:0]  srch_tid;
   logic              srch_hit;
   logic [SLOT_W-1:0] srch_slot;
   logic [DLY_W-1:0]  srch_dly;
   logic              fill_valid;
   logic [SET_W-1:0]  fill_set;
   logic [TAG_W-1:0]  fill_tag;
   logic [TID_W-1:0]  fill_tid;
   logic [SLOT_W-1:0] occupancy;

   miss_countdown_buf uut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_set(push_set), .push_tag(push_tag),
      .push_tid(push_tid), .push_dly(push_dly), .push_full(push_full),
      .srch_set(srch_set), .srch_tag(srch_tag), .srch_tid(srch_tid),
      .srch_hit(srch_hit), .srch_slot(srch_slot), .srch_dly(srch_dly),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
      .fill_tid(fill_tid), .occupancy(occupancy)
   );

   typedef struct {
      int due;
      int s;
      int t;
      int d;
   } fill_t;

   fill_t sb[$];
   int    pe_l[$];
   int    de_l[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   int    last_fill = -10;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int live_at(int c);
      int n = 0;
      for (int k = 0; k < pe_l.size(); k++)
         if (pe_l[k] <= c && de_l[k] > c) n++;
      return n;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // driver: records every accepted push in the scoreboard, sorted by due cycle
   task automatic push(int s, int t, int d, int dl);
      fill_t it;
      int    pos;
      bit    acc;
      acc = live_at(cyc) < DEPTH;
      push_valid = 1'b1;
      push_set = SET_W'(s);
      push_tag = TAG_W'(t);
      push_tid = TID_W'(d);
      push_dly = DLY_W'(dl);
      if (acc) begin
         it.due = cyc + dl + 2;
         it.s = s;
         it.t = t;
         it.d = d;
         pos = sb.size();
         for (int k = 0; k < sb.size(); k++) begin
            if (sb[k].due > it.due) begin
               pos = k;
               break;
            end
         end
         sb.insert(pos, it);
         pe_l.push_back(cyc + 1);
         de_l.push_back(it.due);
      end
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic srch(int s, int t, int d, bit eh, int es, int ed, string req);
      srch_set = SET_W'(s);
      srch_tag = TAG_W'(t);
      srch_tid = TID_W'(d);
      #1;
      check(srch_hit == eh, req, "search hit", int'(srch_hit), int'(eh));
      check(int'(srch_slot) == es, req, "search slot", int'(srch_slot), es);
      check(int'(srch_dly) == ed, req, "search delay", int'(srch_dly), ed);
   endtask

   // monitor: occupancy every cycle, fills against the scoreboard
   always @(negedge clk) begin : mon
      int ex;
      if (rst_n && !done) begin
         check(int'(occupancy) == live_at(cyc), "R10", "occupancy", int'(occupancy), live_at(cyc));
         check(push_full == (live_at(cyc) == DEPTH), "R7", "full flag", int'(push_full),
               int'(live_at(cyc) == DEPTH));
         if (sb.size() > 0) begin
            ex = (sb[0].due > last_fill + 1) ? sb[0].due : last_fill + 1;
            if (fill_valid) begin
               check(cyc == ex, "R4,R6", "fill cycle", cyc, ex);
               check(int'(fill_set) == sb[0].s, "R5", "fill set", int'(fill_set), sb[0].s);
               check(int'(fill_tag) == sb[0].t, "R5", "fill tag", int'(fill_tag), sb[0].t);
               check(int'(fill_tid) == sb[0].d, "R5", "fill tid", int'(fill_tid), sb[0].d);
               last_fill = cyc;
               void'(sb.pop_front());
            end else if (cyc >= ex) begin
               check(1'b0, "R4", "missing fill", 0, 1);
               void'(sb.pop_front());
            end
         end else if (fill_valid) begin
            check(1'b0, "R7", "unexpected fill", 1, 0);
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      push_valid = 1'b0;
      push_set = '0;
      push_tag = '0;
      push_tid = '0;
      push_dly = '0;
      srch_set = '0;
      srch_tag = '0;
      srch_tid = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty after reset
      check(occupancy == '0, "R1", "occupancy", int'(occupancy), 0);
      check(push_full == 1'b0, "R1", "full", int'(push_full), 0);
      check(fill_valid == 1'b0, "R1", "fill valid", int'(fill_valid), 0);
      srch(3, 'h111, 1, 0, 0, 0, "R1");

      // R2 R3: single entry ages one per cycle
      push(3, 'h111, 1, 6);
      srch(3, 'h111, 1, 1, 0, 6, "R2");
      repeat (2) @(negedge clk);
      srch(3, 'h111, 1, 1, 0, 4, "R3");

      // R5: a shorter miss goes ahead of the older one
      push(3, 'h222, 1, 2);
      srch(3, 'h222, 1, 1, 0, 2, "R5");
      srch(3, 'h111, 1, 1, 1, 3, "R5");

      // R9 R8: one field differs -> miss, slot equals occupancy
      srch(3, 'h111, 2, 0, 2, 0, "R9");
      srch(3, 'h112, 1, 0, 2, 0, "R9");
      srch(4, 'h111, 1, 0, 2, 0, "R9");
      repeat (10) @(negedge clk);

      // R6: four entries reach zero together; equal delays keep push order
      push(5, 'h0C0, 3, 5);
      push(5, 'h0D0, 3, 4);
      push(5, 'h0E0, 3, 3);
      srch(5, 'h0E0, 3, 1, 2, 3, "R5");
      srch(5, 'h0C0, 3, 1, 0, 3, "R6");
      push(7, 'h777, 5, 9);
      push(7, 'h777, 5, 1);
      srch(7, 'h777, 5, 1, 3, 1, "R8");
      repeat (20) @(negedge clk);

      // R7: fill up, then a refused push
      for (int i = 0; i < DEPTH; i++) push(i, 'h300 + i, i, 30);
      check(push_full == 1'b1, "R7", "full when five held", int'(push_full), 1);
      push(9, 'h999, 9, 1);
      check(int'(occupancy) == DEPTH, "R7", "occupancy after refused push", int'(occupancy), DEPTH);
      srch(9, 'h999, 9, 0, DEPTH, 0, "R7");
      repeat (45) @(negedge clk);

      // R4: zero delay fill
      push(2, 'h0AB, 6, 0);
      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R4", "all fills seen", sb.size(), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule